// File: doc/BRIEF.md
# Link Self-Test Control Sequencer

This block runs a built-in self-test on a serial link lane group. A small control and status byte holds the settings and the results. Software writes a start bit, and the sequencer arms the receiver to look for the first start delimiter. Once the delimiter arrives, the receiver checks incoming patterns. Every pattern mismatch found while checking raises an error class and advances a saturating error counter. The run ends after a fixed number of pattern loops, or at the first error if stop-on-error is set. With loop-forever set, the run never ends.

Master transmission has two steps. Software arms a register bit. The transmitter becomes master only on the next training set that carries the loopback flag. While the transmitter is master and the sweep bit is set, an inversion mask walks a single one across the transmit lanes.

The link side is reduced to single-cycle strobes: training set seen (with its loopback flag), start delimiter seen, pattern mismatch and pattern loop complete.

States: `ST_IDLE` (no run), `ST_SEEK` (receiver searching for the first delimiter), `ST_RUN` (checking patterns), `ST_HALT` (stopped on error), `ST_DONE` (loop count reached). Transitions:
- IDLE→SEEK when start is 1.
- SEEK→RUN on a delimiter.
- RUN→HALT on a mismatch with stop-on-error set.
- RUN→DONE on the last loop-complete strobe with loop-forever clear.
- SEEK, RUN, HALT and DONE all go back to IDLE when start is cleared.

Top module: `lst_sequencer`

## Requirements
- R1: After reset, `csr_rdata` reads 0x00, `err_count` is 0, and `master_active`, `tx_active`, `rx_search`, `rx_check` and `inv_mask` are all 0.
- R2: One cycle after the start bit becomes 1 in `ST_IDLE`, the run launches. Status reads 01, `rx_search` is 1, `err_count` is 0 and the done bit is cleared.
- R3: A delimiter strobe while searching moves status from 01 to 00 and raises `rx_check` on the next cycle. Mismatch strobes while searching are ignored: the count and the status are unchanged.
- R4: A mismatch while checking sets status to 10. Status stays at 10 through further errors until software clears it or a new run launches. Status never reads 11.
- R5: Each mismatch while checking adds one to `err_count`. The count saturates at 255.
- R6: With stop-on-error set, the first mismatch while checking ends the run on the next cycle. `rx_check` falls, the done bit is set, and later mismatches are not counted.
- R7: With stop-on-error and loop-forever clear, the NUM_PASSES-th loop-complete strobe ends the run. The done bit is set and `rx_check` falls. Before that strobe the done bit stays 0.
- R8: With loop-forever set, loop-complete strobes never end the run: `rx_check` stays 1 and the done bit stays 0.
- R9: `master_active` rises only on a training set with the loopback flag set while the master-arm bit is set and a run is active. `tx_active` is `master_active` while searching or checking.
- R10: Clearing start returns the block to idle one cycle later. `rx_search`, `rx_check`, `tx_active` and `master_active` all go to 0, and status is kept.
- R11: Writing 1 to bit 2 clears the done bit. Writing 1 to bit 6 or bit 7 clears status to 00.
- R12: While sweep is set and `tx_active` is 1, `inv_mask` starts at bit 0 and shifts its single one up by one position per cycle, wrapping from MASK_W-1 to bit 0. At all other times it is zero.
- R13: Register layout of `csr_rdata`: bit0 start, bit1 master arm, bit2 done, bit3 loop forever, bit4 stop on error, bit5 sweep, bits 7:6 status. The five control bits read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value |
| ts_seen | input | 1 | Training set received (one-cycle strobe) |
| ts_loopback | input | 1 | Loopback flag of that training set |
| delim_seen | input | 1 | Start delimiter received |
| mismatch | input | 1 | Received pattern mismatch |
| loop_done | input | 1 | One pattern loop completed |
| master_active | output | 1 | Transmitter acting as master |
| tx_active | output | 1 | Transmit pattern generator enabled |
| rx_search | output | 1 | Receiver searching for the delimiter |
| rx_check | output | 1 | Receiver checking patterns |
| inv_mask | output | MASK_W | Rotating lane inversion mask |
| err_count | output | CNT_W | Saturating error count |

## Verification
The assertions assume that `ts_loopback` matters only in a cycle where `ts_seen` is high. They also assume that software does not rewrite the start bit during a run except to stop it. The bench keeps strobes as single-cycle levels driven after the clock edge. It rewrites the control byte with start held at 1 whenever it changes another field mid-run. In the random phase the control byte is fixed, and only the four link strobes are drawn, so every sequence stays legal.

// File: rtl/lst_pkg.sv
package lst_pkg;

    localparam int CSR_W = 8;

    localparam int B_START  = 0;
    localparam int B_MASTER = 1;
    localparam int B_DONE   = 2;
    localparam int B_LOOP   = 3;
    localparam int B_HALT   = 4;
    localparam int B_SWEEP  = 5;
    localparam int B_STAT_LO = 6;
    localparam int B_STAT_HI = 7;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEEK = 3'd1,
        ST_RUN  = 3'd2,
        ST_HALT = 3'd3,
        ST_DONE = 3'd4
    } lst_state_e;

    typedef enum logic [1:0] {
        STAT_CLEAN    = 2'b00,
        STAT_NO_DELIM = 2'b01,
        STAT_TX_ERR   = 2'b10
    } lst_stat_e;

    typedef struct packed {
        logic sweep;
        logic halt_on_err;
        logic loop_forever;
        logic master_arm;
        logic start;
    } lst_ctl_t;

endpackage

// File: rtl/lst_csr.sv
module lst_csr
    import lst_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CSR_W-1:0]   cfg_wdata,
    input  logic               launch,
    input  logic               finish,
    output lst_ctl_t           ctl,
    output logic               done,
    output logic               stat_sw_clr
);

    lst_ctl_t ctl_q;
    logic     done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (cfg_wr) begin
            ctl_q.start        <= cfg_wdata[B_START];
            ctl_q.master_arm   <= cfg_wdata[B_MASTER];
            ctl_q.loop_forever <= cfg_wdata[B_LOOP];
            ctl_q.halt_on_err  <= cfg_wdata[B_HALT];
            ctl_q.sweep        <= cfg_wdata[B_SWEEP];
        end
    end

    // done: hardware set wins over launch clear, which wins over software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
        end else if (launch) begin
            done_q <= 1'b0;
        end else if (cfg_wr && cfg_wdata[B_DONE]) begin
            done_q <= 1'b0;
        end
    end

    assign ctl         = ctl_q;
    assign done        = done_q;
    assign stat_sw_clr = cfg_wr && (cfg_wdata[B_STAT_HI] || cfg_wdata[B_STAT_LO]);

endmodule

// File: rtl/lst_ctrl_fsm.sv
module lst_ctrl_fsm
    import lst_pkg::*;
#(
    parameter int NUM_PASSES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  lst_ctl_t    ctl,
    input  logic        ts_seen,
    input  logic        ts_loopback,
    input  logic        delim_seen,
    input  logic        mismatch,
    input  logic        loop_done,
    output lst_state_e  state,
    output logic        launch,
    output logic        delim_hit,
    output logic        err_hit,
    output logic        finish,
    output logic        master_active,
    output logic        tx_active,
    output logic        rx_search,
    output logic        rx_check
);

    localparam int PASS_W = (NUM_PASSES > 1) ? $clog2(NUM_PASSES) : 1;
    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NUM_PASSES - 1);

    lst_state_e        state_q, state_d;
    logic [PASS_W-1:0] pass_q;
    logic              master_q;
    logic              last_pass;
    logic              halt_now;
    logic              pass_step;

    assign last_pass = (pass_q == LAST_PASS);
    assign halt_now  = mismatch && ctl.halt_on_err;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctl.start) state_d = ST_SEEK;
            end
            ST_SEEK: begin
                if (!ctl.start)     state_d = ST_IDLE;
                else if (delim_seen) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!ctl.start)
                    state_d = ST_IDLE;
                else if (halt_now)
                    state_d = ST_HALT;
                else if (loop_done && last_pass && !ctl.loop_forever)
                    state_d = ST_DONE;
            end
            ST_HALT: begin
                if (!ctl.start) state_d = ST_IDLE;
            end
            ST_DONE: begin
                if (!ctl.start) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        launch    = 1'b0;
        delim_hit = 1'b0;
        err_hit   = 1'b0;
        rx_search = 1'b0;
        rx_check  = 1'b0;
        pass_step = 1'b0;
        unique case (state_q)
            ST_IDLE: launch = ctl.start;
            ST_SEEK: begin
                rx_search = 1'b1;
                delim_hit = ctl.start && delim_seen;
            end
            ST_RUN: begin
                rx_check  = 1'b1;
                err_hit   = ctl.start && mismatch;
                pass_step = ctl.start && loop_done && !halt_now;
            end
            ST_HALT, ST_DONE: ;
            default: ;
        endcase
        finish    = (state_q == ST_RUN) &&
                    ((state_d == ST_HALT) || (state_d == ST_DONE));
        tx_active = master_q && (rx_search || rx_check);
    end

    // pattern loop counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_q <= '0;
        end else if (launch) begin
            pass_q <= '0;
        end else if (pass_step) begin
            pass_q <= last_pass ? '0 : pass_q + 1'b1;
        end
    end

    // master entry on the next loopback training set after arming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q <= 1'b0;
        end else if (!ctl.start || state_q == ST_IDLE) begin
            master_q <= 1'b0;
        end else if (ts_seen && ts_loopback && ctl.master_arm) begin
            master_q <= 1'b1;
        end
    end

    assign state         = state_q;
    assign master_active = master_q;

endmodule

// File: rtl/lst_err_track.sv
module lst_err_track
    import lst_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             delim_hit,
    input  logic             err_hit,
    input  logic             sw_clr,
    output logic [1:0]       status,
    output logic [CNT_W-1:0] err_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    lst_stat_e        stat_q;
    logic [CNT_W-1:0] cnt_q;

    // status: error wins, then delimiter, then software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= STAT_CLEAN;
        end else if (launch) begin
            stat_q <= STAT_NO_DELIM;
        end else if (err_hit) begin
            stat_q <= STAT_TX_ERR;
        end else if (delim_hit && stat_q == STAT_NO_DELIM) begin
            stat_q <= STAT_CLEAN;
        end else if (sw_clr) begin
            stat_q <= STAT_CLEAN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (launch) begin
            cnt_q <= '0;
        end else if (err_hit && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign status    = stat_q;
    assign err_count = cnt_q;

endmodule

// File: rtl/lst_inv_mask.sv
module lst_inv_mask #(
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    output logic [MASK_W-1:0] mask
);

    localparam logic [MASK_W-1:0] SEED = MASK_W'(1);

    logic [MASK_W-1:0] rot_q;

    generate
        if (MASK_W == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) rot_q <= SEED;
                else        rot_q <= SEED;
            end
        end else begin : g_rotate
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      rot_q <= SEED;
                else if (enable) rot_q <= {rot_q[MASK_W-2:0], rot_q[MASK_W-1]};
                else             rot_q <= SEED;
            end
        end
    endgenerate

    assign mask = enable ? rot_q : '0;

endmodule

// File: rtl/lst_sequencer.sv
module lst_sequencer
    import lst_pkg::*;
#(
    parameter int NUM_PASSES = 4,
    parameter int MASK_W     = 8,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        csr_rdata,
    input  logic              ts_seen,
    input  logic              ts_loopback,
    input  logic              delim_seen,
    input  logic              mismatch,
    input  logic              loop_done,
    output logic              master_active,
    output logic              tx_active,
    output logic              rx_search,
    output logic              rx_check,
    output logic [MASK_W-1:0] inv_mask,
    output logic [CNT_W-1:0]  err_count
);

    lst_ctl_t   ctl;
    lst_state_e state_q;
    logic       done;
    logic       stat_sw_clr;
    logic       launch;
    logic       delim_hit;
    logic       err_hit;
    logic       finish;
    logic [1:0] status;

    lst_csr u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .launch      (launch),
        .finish      (finish),
        .ctl         (ctl),
        .done        (done),
        .stat_sw_clr (stat_sw_clr)
    );

    lst_ctrl_fsm #(.NUM_PASSES(NUM_PASSES)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl           (ctl),
        .ts_seen       (ts_seen),
        .ts_loopback   (ts_loopback),
        .delim_seen    (delim_seen),
        .mismatch      (mismatch),
        .loop_done     (loop_done),
        .state         (state_q),
        .launch        (launch),
        .delim_hit     (delim_hit),
        .err_hit       (err_hit),
        .finish        (finish),
        .master_active (master_active),
        .tx_active     (tx_active),
        .rx_search     (rx_search),
        .rx_check      (rx_check)
    );

    lst_err_track #(.CNT_W(CNT_W)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .delim_hit (delim_hit),
        .err_hit   (err_hit),
        .sw_clr    (stat_sw_clr),
        .status    (status),
        .err_count (err_count)
    );

    lst_inv_mask #(.MASK_W(MASK_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ctl.sweep && tx_active),
        .mask   (inv_mask)
    );

    assign csr_rdata = {status, ctl.sweep, ctl.halt_on_err, ctl.loop_forever,
                        done, ctl.master_arm, ctl.start};

endmodule

// File: rtl/lst_checker.sv
module lst_checker
    import lst_pkg::*;
#(
    parameter int MASK_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    input  logic [7:0]        csr_rdata,
    input  logic              mismatch,
    input  logic              master_active,
    input  logic              tx_active,
    input  logic              rx_search,
    input  logic              rx_check,
    input  logic [MASK_W-1:0] inv_mask,
    input  logic [CNT_W-1:0]  err_count,
    input  lst_state_e        state_q,
    input  logic              launch
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_status_not_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[7:6] != 2'b11);

    assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[7:6] == 2'b10 && !launch && !(cfg_wr && (cfg_wdata[7] || cfg_wdata[6])))
        |=> csr_rdata[7:6] == 2'b10);

    assert_count_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == CNT_MAX && !launch) |=> err_count == CNT_MAX);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

    assert_halt_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && rx_check && mismatch && csr_rdata[4] && csr_rdata[0])
        |=> (!rx_check && csr_rdata[2]));

    assert_tx_needs_master_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> master_active);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> (!tx_active && !rx_search && !rx_check));

    assert_mask_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inv_mask));

    assert_mask_needs_tx_R12: assert property (@(posedge clk) disable iff (!rst_n)
        inv_mask != '0 |-> (tx_active && csr_rdata[5]));

endmodule

bind lst_sequencer lst_checker #(.MASK_W(MASK_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr        (cfg_wr),
    .cfg_wdata     (cfg_wdata),
    .csr_rdata     (csr_rdata),
    .mismatch      (mismatch),
    .master_active (master_active),
    .tx_active     (tx_active),
    .rx_search     (rx_search),
    .rx_check      (rx_check),
    .inv_mask      (inv_mask),
    .err_count     (err_count),
    .state_q       (state_q),
    .launch        (launch)
);

// File: tb/lst_sequencer_test.sv
module lst_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_PASSES = 4;
    localparam int MASK_W     = 8;
    localparam int CNT_W      = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic [7:0]        csr_rdata;
    logic              ts_seen = 1'b0;
    logic              ts_loopback = 1'b0;
    logic              delim_seen = 1'b0;
    logic              mismatch = 1'b0;
    logic              loop_done = 1'b0;
    logic              master_active;
    logic              tx_active;
    logic              rx_search;
    logic              rx_check;
    logic [MASK_W-1:0] inv_mask;
    logic [CNT_W-1:0]  err_count;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lst_sequencer #(.NUM_PASSES(NUM_PASSES), .MASK_W(MASK_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .csr_rdata(csr_rdata), .ts_seen(ts_seen), .ts_loopback(ts_loopback),
        .delim_seen(delim_seen), .mismatch(mismatch), .loop_done(loop_done),
        .master_active(master_active), .tx_active(tx_active),
        .rx_search(rx_search), .rx_check(rx_check),
        .inv_mask(inv_mask), .err_count(err_count)
    );

    // control byte: bit0 start, bit1 master, bit3 loop, bit4 halt, bit5 sweep
    function automatic logic [7:0] ctl(input bit st, input bit ms, input bit lp,
                                       input bit ht, input bit sw);
        return {2'b00, sw, ht, lp, 1'b0, ms, st};
    endfunction

    function automatic int sat_inc(input int v);
        return (v >= 255) ? 255 : v + 1;
    endfunction

    function automatic logic [MASK_W-1:0] mask_at(input int k);
        return MASK_W'(1) << (k % MASK_W);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic csr_write(input logic [7:0] d);
        cfg_wr = 1'b1;
        cfg_wdata = d;
        step();
        cfg_wr = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic pulse_delim();
        delim_seen = 1'b1; step(); delim_seen = 1'b0;
    endtask

    task automatic pulse_mis();
        mismatch = 1'b1; step(); mismatch = 1'b0;
    endtask

    task automatic pulse_loop();
        loop_done = 1'b1; step(); loop_done = 1'b0;
    endtask

    task automatic pulse_ts(input bit lb);
        ts_seen = 1'b1; ts_loopback = lb; step(); ts_seen = 1'b0; ts_loopback = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic launch_run(input logic [7:0] c);
        csr_write(c);
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int exp_cnt;
        bit any_err;
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        check("R1 csr", csr_rdata, 8'h00);
        check("R1 count", err_count, 0);
        check("R1 outs", {master_active, tx_active, rx_search, rx_check}, 4'b0);
        check("R1 mask", inv_mask, 0);

        // R13 layout: control bits read back, done/status writes have no set effect
        csr_write(8'hFA);
        check("R13 readback", csr_rdata, 8'h3A);
        csr_write(8'h00);

        // R2 launch
        launch_run(ctl(1, 0, 0, 0, 0));
        check("R2 status", csr_rdata[7:6], 2'b01);
        check("R2 search", rx_search, 1);
        check("R2 count", err_count, 0);

        // R3 mismatch ignored while searching, delimiter clears status
        pulse_mis();
        check("R3 ignored count", err_count, 0);
        check("R3 ignored status", csr_rdata[7:6], 2'b01);
        pulse_delim();
        check("R3 status", csr_rdata[7:6], 2'b00);
        check("R3 checking", {rx_search, rx_check}, 2'b01);

        // R4 first error, sticky
        pulse_mis();
        check("R4 status", csr_rdata[7:6], 2'b10);
        check("R5 count1", err_count, 1);
        pulse_mis();
        pulse_mis();
        check("R4 sticky", csr_rdata[7:6], 2'b10);
        check("R5 count3", err_count, 3);

        // R11 status write-1-to-clear
        csr_write(ctl(1, 0, 0, 0, 0) | 8'h80);
        check("R11 status clr", csr_rdata[7:6], 2'b00);
        check("R11 still running", rx_check, 1);

        // R10 stop
        csr_write(ctl(0, 0, 0, 0, 0));
        step();
        check("R10 idle", {rx_search, rx_check, tx_active, master_active}, 4'b0);
        check("R10 count kept", err_count, 3);

        // R7 finite run
        do_reset();
        launch_run(ctl(1, 0, 0, 0, 0));
        pulse_delim();
        for (int i = 0; i < NUM_PASSES - 1; i++) pulse_loop();
        check("R7 not done yet", {csr_rdata[2], rx_check}, 2'b01);
        pulse_loop();
        check("R7 done", {csr_rdata[2], rx_check}, 2'b10);
        check("R7 status clean", csr_rdata[7:6], 2'b00);

        // R11 done write-1-to-clear
        csr_write(ctl(1, 0, 0, 0, 0) | 8'h04);
        check("R11 done clr", csr_rdata[2], 0);

        // R2 relaunch clears done
        csr_write(ctl(1, 0, 0, 0, 0));
        pulse_loop();
        csr_write(ctl(0, 0, 0, 0, 0));
        step();
        launch_run(ctl(1, 0, 0, 0, 0));
        check("R2 relaunch", {csr_rdata[7:6], csr_rdata[2], rx_search}, 4'b0101);

        // R6 stop on error
        do_reset();
        launch_run(ctl(1, 0, 0, 1, 0));
        pulse_delim();
        pulse_mis();
        check("R6 halted", {rx_check, csr_rdata[2]}, 2'b01);
        check("R6 status", csr_rdata[7:6], 2'b10);
        pulse_mis();
        check("R6 no more count", err_count, 1);

        // R8 loop forever
        do_reset();
        launch_run(ctl(1, 0, 1, 0, 0));
        pulse_delim();
        for (int i = 0; i < 2 * NUM_PASSES + 1; i++) pulse_loop();
        check("R8 running", {rx_check, csr_rdata[2]}, 2'b10);

        // R9 master entry rules
        do_reset();
        launch_run(ctl(1, 0, 0, 0, 0));
        pulse_ts(1);
        check("R9 unarmed", {master_active, tx_active}, 2'b00);
        csr_write(ctl(1, 1, 0, 0, 0));
        pulse_ts(0);
        check("R9 no loopback", master_active, 0);
        pulse_ts(1);
        check("R9 master", {master_active, tx_active}, 2'b11);

        // R12 inversion sweep
        check("R12 off", inv_mask, 0);
        csr_write(ctl(1, 1, 0, 0, 1));
        for (int k = 0; k < MASK_W + 3; k++) begin
            check("R12 rotate", inv_mask, mask_at(k));
            step();
        end
        csr_write(ctl(1, 1, 0, 0, 0));
        check("R12 disabled", inv_mask, 0);
        csr_write(ctl(0, 1, 0, 0, 1));
        step();
        check("R10 master drops", {master_active, tx_active, inv_mask}, 0);

        // R5 saturation
        do_reset();
        launch_run(ctl(1, 0, 0, 0, 0));
        pulse_delim();
        mismatch = 1'b1;
        repeat (300) step();
        mismatch = 1'b0;
        check("R5 saturate", err_count, 255);
        step();
        check("R5 hold", err_count, 255);

        // random phase: R4, R5, R8
        do_reset();
        launch_run(ctl(1, 0, 1, 0, 0));
        pulse_delim();
        exp_cnt = 0;
        any_err = 0;
        for (int c = 0; c < 600; c++) begin
            mismatch  = ($urandom % 4) == 0;
            loop_done = ($urandom % 3) == 0;
            ts_seen   = ($urandom % 5) == 0;
            ts_loopback = $urandom % 2;
            if (mismatch) begin
                exp_cnt = sat_inc(exp_cnt);
                any_err = 1;
            end
            step();
            if (c % 50 == 49) begin
                check("R5 random count", err_count, exp_cnt);
                check("R4 random status", csr_rdata[7:6], any_err ? 2'b10 : 2'b00);
                check("R8 random running", {rx_check, csr_rdata[2]}, 2'b10);
            end
        end
        mismatch = 0; loop_done = 0; ts_seen = 0; ts_loopback = 0;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule